// File: doc/BRIEF.md
# Chip-Enable Write-Protect Gate

This block sits in the path between a processor's active-low chip-enable and the chip-enable pin of a memory. It keeps a brown-out or supervisory reset from turning into a corrupted write. When the supervisory reset is inactive, the memory sees the processor's enable unchanged. When the reset becomes active and no access is in flight, the gate closes at once and holds the memory's enable inactive (high). When an access is in flight, the gate stays open so that the access can complete. It closes when the enable returns high, or when a fixed guard time has passed since the reset was seen, whichever comes first.

The supervisory reset and the incoming enable are both brought into the clock domain through two-flop synchronisers. A three-state controller (pass, draining, blocked) then decides whether the gate is open. The guard time is given in nanoseconds and converted to clock cycles from a clock-frequency parameter, rounded up. A status output reports whether the gate is open.

Top module: `ce_guard`

## Requirements
- R1: While the gate is in pass mode, `ce_out_n` equals `ce_in_n` as it was two clock edges earlier, which is the synchroniser latency.
- R2: While `rst_n` is low, the controller is in the blocked state, `ce_out_n` is 1 and `gate_open` is 0.
- R3: If the synchronised `ce_in_n` is 1 when the synchronised `sup_reset` becomes 1, `gate_open` falls on the third rising clock edge after `sup_reset` was driven high.
- R4: If the synchronised `ce_in_n` is 0 when the synchronised `sup_reset` becomes 1, the gate enters draining, `gate_open` stays 1 and `ce_out_n` keeps following the input.
- R5: In draining, a rise of `ce_in_n` closes the gate on the third rising edge after the rise. `ce_out_n` goes high one edge earlier.
- R6: Draining lasts at most HOLD_CYC cycles, where HOLD_CYC = ceil(CLK_FREQ_HZ × HOLD_NS / 10^9). With the input held low, `gate_open` is still 1 after edge HOLD_CYC+2 and is 0 after edge HOLD_CYC+3, counting from the edge-aligned assertion of `sup_reset`.
- R7: While the gate is closed, `ce_out_n` is 1 whatever `ce_in_n` does.
- R8: Once the gate is closed, it stays closed while `sup_reset` remains 1, even if `ce_in_n` goes low again.
- R9: The gate reopens into pass mode on the third rising edge after `sup_reset` is driven low. This also applies after `rst_n` is released.
- R10: If `sup_reset` falls during draining, the gate returns to pass mode without closing.
- R11: `gate_open` is 1 exactly when the controller is in pass or draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sup_reset | input | 1 | Supervisory reset, active high, asynchronous to clk |
| ce_in_n | input | 1 | Processor chip-enable, active low |
| ce_out_n | output | 1 | Gated chip-enable to memory, active low |
| gate_open | output | 1 | High while the gate is in pass or draining |

## Verification
The bench builds the block with CLK_FREQ_HZ = 1,100,000 and HOLD_NS = 15,000. The product of these is 16.5 cycles, so the rounding-up rule is exercised and the guard time becomes 17 cycles. A short guard time like this lets a single run reach the exact timeout boundary many times, both in directed drains and in random traffic. Long random runs of an active-low enable then hit timeouts, early input rises and reset drops during draining, one after another.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;
  typedef enum logic [1:0] {
    GATE_BLOCK = 2'd0,
    GATE_PASS  = 2'd1,
    GATE_DRAIN = 2'd2
  } gate_state_e;
endpackage

// File: rtl/ce_sync2.sv
module ce_sync2 #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  genvar gi;
  generate
    for (gi = 0; gi < int'(W); gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[gi] <= RST_VAL[gi];
          sync_q[gi] <= RST_VAL[gi];
        end else begin
          meta_q[gi] <= d[gi];
          sync_q[gi] <= meta_q[gi];
        end
      end
    end
  endgenerate

  assign q = sync_q;
endmodule

// File: rtl/ce_drain_timer.sv
module ce_drain_timer #(
  parameter int unsigned HOLD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = run && (cnt_q == LAST);
  assign cnt_en  = !run || !expired;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/ce_gate_fsm.sv
module ce_gate_fsm
  import ce_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sup_act,
  input  logic        ce_hi,
  input  logic        tmo,
  output gate_state_e state,
  output logic        draining
);
  gate_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!sup_act) begin
      st_d = GATE_PASS;
    end else begin
      case (st_q)
        GATE_PASS:  st_d = ce_hi ? GATE_BLOCK : GATE_DRAIN;
        GATE_DRAIN: if (ce_hi || tmo) st_d = GATE_BLOCK;
        default:    st_d = GATE_BLOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GATE_BLOCK;
    else        st_q <= st_d;
  end

  assign state    = st_q;
  assign draining = (st_q == GATE_DRAIN);

  p_idle_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GATE_PASS && sup_act && ce_hi) |=> (st_q == GATE_BLOCK));
  p_busy_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GATE_PASS && sup_act && !ce_hi) |=> (st_q == GATE_DRAIN));
  p_drain_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GATE_DRAIN && sup_act && tmo) |=> (st_q == GATE_BLOCK));
  p_stay_shut_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GATE_BLOCK && sup_act) |=> (st_q == GATE_BLOCK));
  p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_act |=> (st_q == GATE_PASS));
  p_legal_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GATE_BLOCK) || (st_q == GATE_PASS) || (st_q == GATE_DRAIN));
endmodule

// File: rtl/ce_guard.sv
module ce_guard
  import ce_guard_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int unsigned HOLD_NS     = 15_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_reset,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic gate_open
);
  localparam logic [63:0] HOLD_PROD = 64'(CLK_FREQ_HZ) * 64'(HOLD_NS);
  localparam logic [63:0] HOLD_RAW  = (HOLD_PROD + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int unsigned HOLD_CYC  = (HOLD_RAW == 64'd0) ? 1 : int'(HOLD_RAW);

  logic [1:0]  sync_q;
  logic        sup_s, ce_s;
  logic        tmo, draining;
  gate_state_e state;

  ce_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sup_reset, ce_in_n}),
    .q     (sync_q)
  );
  assign sup_s = sync_q[1];
  assign ce_s  = sync_q[0];

  ce_drain_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (draining),
    .expired (tmo)
  );

  ce_gate_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup_act  (sup_s),
    .ce_hi    (ce_s),
    .tmo      (tmo),
    .state    (state),
    .draining (draining)
  );

  assign gate_open = (state != GATE_BLOCK);
  assign ce_out_n  = gate_open ? ce_s : 1'b1;

  p_drain_exits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && sup_s && ce_s) |=> !gate_open);
  p_drain_keeps_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !sup_s) |=> (gate_open && !draining));
endmodule

// File: tb/test_ce_guard.sv
module test_ce_guard;
  localparam int unsigned CLK_HZ  = 1_100_000;
  localparam int unsigned HOLD_NS = 15_000;
  // 1.1 MHz * 15 us = 16.5 cycles, rounded up
  localparam int EXP_HOLD = 17;

  logic clk = 1'b0;
  logic rst_n, sup_reset, ce_in_n;
  logic ce_out_n, gate_open;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // bench model: synchroniser stages and controller (0 closed, 1 pass, 2 drain)
  logic m_r1, m_r2, m_c1, m_c2;
  int   m_st, m_cnt;

  always #4 clk = ~clk;

  ce_guard #(.CLK_FREQ_HZ(CLK_HZ), .HOLD_NS(HOLD_NS)) i_ce_guard (
    .clk(clk), .rst_n(rst_n), .sup_reset(sup_reset),
    .ce_in_n(ce_in_n), .ce_out_n(ce_out_n), .gate_open(gate_open)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_open();
    return (m_st != 0);
  endfunction

  function automatic logic exp_out();
    return (m_st == 0) ? 1'b1 : m_c2;
  endfunction

  task automatic model_reset();
    m_r1 = 1'b1; m_r2 = 1'b1; m_c1 = 1'b1; m_c2 = 1'b1;
    m_st = 0; m_cnt = 0;
  endtask

  task automatic model_edge();
    int nst;
    nst = m_st;
    if (!m_r2) begin
      nst = 1;
    end else if (m_st == 1) begin
      nst = m_c2 ? 0 : 2;
    end else if (m_st == 2) begin
      if (m_c2 || m_cnt == EXP_HOLD - 1) nst = 0;
    end
    m_cnt = (m_st == 2) ? m_cnt + 1 : 0;
    m_st  = nst;
    m_r2 = m_r1; m_r1 = sup_reset;
    m_c2 = m_c1; m_c1 = ce_in_n;
  endtask

  task automatic cyc(input logic sr, input logic ce);
    sup_reset = sr;
    ce_in_n   = ce;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R11", gate_open, exp_open());
    chk(exp_open() ? "R1" : "R7", ce_out_n, exp_out());
  endtask

  initial begin
    #(200_000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic sr_l, ce_l;
    int   slow;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sup_reset = 1'b0; ce_in_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R2", gate_open, 1'b0);
    chk("R2", ce_out_n, 1'b1);
    rst_n = 1'b1;

    // R9 after block reset release
    cyc(0, 1); cyc(0, 1);
    chk("R9", gate_open, 1'b0);
    cyc(0, 1);
    chk("R9", gate_open, 1'b1);

    // R1 pass-through latency
    cyc(0, 0);
    chk("R1", ce_out_n, 1'b1);
    cyc(0, 0);
    chk("R1", ce_out_n, 1'b0);
    cyc(0, 1); cyc(0, 1);
    chk("R1", ce_out_n, 1'b1);

    // R3 idle enable: immediate cut
    cyc(1, 1); cyc(1, 1);
    chk("R3", gate_open, 1'b1);
    cyc(1, 1);
    chk("R3", gate_open, 1'b0);
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    chk("R9", gate_open, 1'b1);

    // R4 / R6 access held until timeout
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    for (int k = 1; k <= EXP_HOLD + 3; k++) begin
      cyc(1, 0);
      if (k == 3) begin
        chk("R4", gate_open, 1'b1);
        chk("R4", ce_out_n, 1'b0);
      end
      if (k == EXP_HOLD + 2) chk("R6", gate_open, 1'b1);
      if (k == EXP_HOLD + 3) chk("R6", gate_open, 1'b0);
    end
    // R8 / R7 closed gate ignores a fresh access
    cyc(1, 1); cyc(1, 0); cyc(1, 0); cyc(1, 0);
    chk("R8", gate_open, 1'b0);
    chk("R7", ce_out_n, 1'b1);
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    chk("R9", gate_open, 1'b1);
    chk("R1", ce_out_n, 1'b0);

    // R5 early end of access
    cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0);
    cyc(1, 1); cyc(1, 1);
    chk("R5", gate_open, 1'b1);
    chk("R5", ce_out_n, 1'b1);
    cyc(1, 1);
    chk("R5", gate_open, 1'b0);
    cyc(0, 1); cyc(0, 1); cyc(0, 1);
    cyc(0, 0); cyc(0, 0); cyc(0, 0);

    // R10 supervisory reset drops during draining
    for (int k = 0; k < 5; k++) cyc(1, 0);
    for (int k = 0; k < EXP_HOLD + 5; k++) begin
      cyc(0, 0);
      chk("R10", gate_open, 1'b1);
    end

    // random traffic against the model
    sr_l = 1'b0; ce_l = 1'b0; slow = 0;
    for (int k = 0; k < 6000; k++) begin
      if (k % 250 == 0) slow = ($urandom % 2);
      if ($urandom % 40 == 0) sr_l = ~sr_l;
      if ($urandom % (slow ? 30 : 4) == 0) ce_l = ~ce_l;
      cyc(sr_l, ce_l);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule